// File: doc/BRIEF.md
# Occupancy-Gated Burst Copy Engine

This block copies one contiguous range of bytes from a source address to a destination address through a 16-entry, 64-bit channel buffer. A pulse on `start` takes a source address, a destination address and a byte count as one descriptor. From then on, two command generators work independently of each other. The read generator cuts the source range into bursts of at most four 8-byte beats. It issues a burst only after it has reserved buffer room for every beat that burst will return. The write generator cuts the destination range the same way. It issues a burst only when enough returned data, not yet claimed by an earlier write burst, is sitting in the buffer.

Neither generator lets a burst cross a 32-byte address window. A range that starts in the middle of a window therefore gets a short first burst, and every burst after it is aligned. Returned read data enters the buffer in arrival order and leaves it on the write data port in the same order. A one-cycle `done` pulse closes the transfer.

Top module: `burst_mover`

## Requirements
- R1: After reset, `rd_cmd_valid`, `wr_cmd_valid`, `wr_data_valid` and `done` are all low.
- R2: Each read burst has `rd_cmd_beats` = min(beats still to be read, 4 − address bits [4:3]), with a beat being 8 bytes. The next burst address is the previous one plus 8 × beats. A burst request is held with the same address and length until `rd_cmd_ready` accepts it.
- R3: A read burst is offered only when buffer occupancy plus beats still to be returned plus the new burst's beats is at most 16. Read data is accepted in every cycle where `rd_data_valid` is high, with no ready signal, and never overflows the buffer.
- R4: Write bursts follow the rule of R2 on the destination range: length = min(beats still to write, 4 − address bits [4:3]), and the address advances by 8 × beats.
- R5: A write burst is offered only when the buffered data not yet claimed by earlier write bursts is at least the burst's beat count.
- R6: `wr_data_valid` is high exactly while beats of accepted write bursts remain unsent. The words on `wr_data` appear in the order in which read data arrived.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the transfer's final write beat.
- R8: `start` has no effect while a transfer is in progress, when the byte count is zero, or when the byte count is not a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the descriptor on the next three inputs |
| src_addr | input | 32 | Source start address (8-byte aligned) |
| dst_addr | input | 32 | Destination start address (8-byte aligned) |
| byte_cnt | input | 16 | Bytes to move |
| done | output | 1 | One-cycle pulse when the transfer completes |
| rd_cmd_valid | output | 1 | Read burst request |
| rd_cmd_ready | input | 1 | Read burst accepted |
| rd_cmd_addr | output | 32 | Read burst address |
| rd_cmd_beats | output | 3 | Read burst length in beats (1 to 4) |
| rd_data_valid | input | 1 | Returned read beat present |
| rd_data | input | 64 | Returned read beat |
| wr_cmd_valid | output | 1 | Write burst request |
| wr_cmd_ready | input | 1 | Write burst accepted |
| wr_cmd_addr | output | 32 | Write burst address |
| wr_cmd_beats | output | 3 | Write burst length in beats (1 to 4) |
| wr_data_valid | output | 1 | Write beat present |
| wr_data_ready | input | 1 | Write beat accepted |
| wr_data | output | 64 | Write beat |

## Verification
Transfers with both ends aligned to a 32-byte window are compared against transfers that start at offsets 8, 16 and 24. This separates correct first-burst shortening from plain four-beat splitting, and source and destination are given different offsets so that the two generators cannot hide each other's errors. A long copy with a slow write acceptor fills the buffer and shows whether read bursts stop at the 16-beat reservation limit. A long copy with slowly returning reads shows whether write bursts wait for data. Single-beat, exactly-one-window and randomly back-pressured copies, plus starts given while busy or with a zero or unaligned count, cover the pulse timing of `done` and the cases where `start` must be ignored.

// File: rtl/mover_pkg.sv
package mover_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int MAX_BEATS  = 4;
    localparam int DATA_W     = 64;
    localparam int BEATS_W    = 3;
endpackage

// File: rtl/mover_cmd_gen.sv
module mover_cmd_gen
    import mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEFT_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEFT_W-1:0] load_beats,
    input  logic              gate_ok,
    input  logic              cmd_ready,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BEATS_W-1:0] cmd_beats
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEFT_W-1:0] left;
    } gen_t;

    gen_t st_q, st_d;
    logic [BEATS_W-1:0] room;
    logic               fire;

    always_comb begin
        room      = BEATS_W'(MAX_BEATS) - {1'b0, st_q.addr[4:3]};
        cmd_beats = (st_q.left < LEFT_W'(room)) ? st_q.left[BEATS_W-1:0] : room;
        cmd_addr  = st_q.addr;
        cmd_valid = (st_q.left != '0) && gate_ok;
        fire      = cmd_valid && cmd_ready;
        st_d      = st_q;
        if (load) begin
            st_d.addr = load_addr;
            st_d.left = load_beats;
        end else if (fire) begin
            st_d.addr = st_q.addr + ADDR_W'({cmd_beats, 3'b000});
            st_d.left = st_q.left - LEFT_W'(cmd_beats);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 / R4: a burst never leaves its 32-byte window
    p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_addr[4:3]} + {1'b0, cmd_beats}) <= 4'd4);
    p_beats_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_beats != '0);
    // R2: request held until taken
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !load |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_beats));
endmodule

// File: rtl/mover_chan_fifo.sv
module mover_chan_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [OCC_W-1:0] cnt;
    } ptr_t;

    ptr_t   st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == PTR_W'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == PTR_W'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + OCC_W'(push) - OCC_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= push_data;
    end

    assign pop_data = mem_q[st_q.rp];
    assign count    = st_q.cnt;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> count < OCC_W'(DEPTH));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/burst_mover.sv
module burst_mover
    import mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  src_addr,
    input  logic [ADDR_W-1:0]  dst_addr,
    input  logic [CNT_W-1:0]   byte_cnt,
    output logic               done,
    output logic               rd_cmd_valid,
    input  logic               rd_cmd_ready,
    output logic [ADDR_W-1:0]  rd_cmd_addr,
    output logic [BEATS_W-1:0] rd_cmd_beats,
    input  logic               rd_data_valid,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               wr_cmd_valid,
    input  logic               wr_cmd_ready,
    output logic [ADDR_W-1:0]  wr_cmd_addr,
    output logic [BEATS_W-1:0] wr_cmd_beats,
    output logic               wr_data_valid,
    input  logic               wr_data_ready,
    output logic [DATA_W-1:0]  wr_data
);
    localparam int LEFT_W = CNT_W - 3;
    localparam int OCC_W  = $clog2(DEPTH+1);
    localparam int CMP_W  = OCC_W + 1;

    typedef struct packed {
        logic [OCC_W-1:0]  resv;   // buffered + in-flight read beats
        logic [OCC_W-1:0]  avail;  // buffered beats not yet claimed by a write burst
        logic [OCC_W-1:0]  wpend;  // claimed beats still to send
        logic [LEFT_W-1:0] left;   // beats of the transfer still to write
        logic              done;
    } ctl_t;

    ctl_t st_q, st_d;
    logic start_ok, rd_ok, wr_ok, rd_fire, wr_fire, pop;
    logic [OCC_W-1:0] fifo_cnt;

    always_comb begin
        start_ok = start && (st_q.left == '0) && (byte_cnt[2:0] == 3'b000)
                   && (byte_cnt[CNT_W-1:3] != '0);
        rd_ok    = (CMP_W'(st_q.resv) + CMP_W'(rd_cmd_beats)) <= CMP_W'(DEPTH);
        wr_ok    = CMP_W'(st_q.avail) >= CMP_W'(wr_cmd_beats);
        rd_fire  = rd_cmd_valid && rd_cmd_ready;
        wr_fire  = wr_cmd_valid && wr_cmd_ready;
        wr_data_valid = st_q.wpend != '0;
        pop      = wr_data_valid && wr_data_ready;

        st_d       = st_q;
        st_d.resv  = st_q.resv + (rd_fire ? OCC_W'(rd_cmd_beats) : '0) - OCC_W'(pop);
        st_d.avail = st_q.avail + OCC_W'(rd_data_valid) - (wr_fire ? OCC_W'(wr_cmd_beats) : '0);
        st_d.wpend = st_q.wpend + (wr_fire ? OCC_W'(wr_cmd_beats) : '0) - OCC_W'(pop);
        st_d.done  = pop && (st_q.left == LEFT_W'(1));
        if (start_ok)  st_d.left = byte_cnt[CNT_W-1:3];
        else if (pop)  st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;

    mover_cmd_gen #(.ADDR_W(ADDR_W), .LEFT_W(LEFT_W)) rd_gen_i (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .load_addr(src_addr),
        .load_beats(byte_cnt[CNT_W-1:3]), .gate_ok(rd_ok), .cmd_ready(rd_cmd_ready),
        .cmd_valid(rd_cmd_valid), .cmd_addr(rd_cmd_addr), .cmd_beats(rd_cmd_beats)
    );

    mover_cmd_gen #(.ADDR_W(ADDR_W), .LEFT_W(LEFT_W)) wr_gen_i (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .load_addr(dst_addr),
        .load_beats(byte_cnt[CNT_W-1:3]), .gate_ok(wr_ok), .cmd_ready(wr_cmd_ready),
        .cmd_valid(wr_cmd_valid), .cmd_addr(wr_cmd_addr), .cmd_beats(wr_cmd_beats)
    );

    mover_chan_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rd_data_valid), .push_data(rd_data),
        .pop(pop), .pop_data(wr_data), .count(fifo_cnt)
    );

    p_resv_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(st_q.resv) <= CMP_W'(DEPTH));
    p_wr_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_valid |-> CMP_W'(fifo_cnt) >= CMP_W'(st_q.wpend) + CMP_W'(wr_cmd_beats));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(pop));
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && (st_q.left > LEFT_W'(1)) |=> st_q.left < $past(st_q.left) || $stable(st_q.left));
endmodule

// File: tb/burst_mover_tb_top.sv
`timescale 1ns/100ps
module burst_mover_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic        done, rd_cmd_valid, wr_cmd_valid, wr_data_valid;
    logic        rd_cmd_ready = 1'b0, wr_cmd_ready = 1'b0, wr_data_ready = 1'b0;
    logic        rd_data_valid = 1'b0;
    logic [63:0] rd_data = '0, wr_data;
    logic [31:0] rd_cmd_addr, wr_cmd_addr;
    logic [2:0]  rd_cmd_beats, wr_cmd_beats;

    always #2.5 clk = ~clk;

    burst_mover dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .byte_cnt(byte_cnt), .done(done),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
        .rd_cmd_beats(rd_cmd_beats), .rd_data_valid(rd_data_valid), .rd_data(rd_data),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr),
        .wr_cmd_beats(wr_cmd_beats), .wr_data_valid(wr_data_valid),
        .wr_data_ready(wr_data_ready), .wr_data(wr_data)
    );

    int n_cmp = 0, n_bad = 0;
    int rd_pct = 100, ret_pct = 100, wc_pct = 100, wd_pct = 100;

    // behavioural reference state
    int unsigned m_rd_addr, m_wr_addr;
    int m_rd_left, m_wr_left, m_rd_out, m_wpend, m_left;
    bit m_done;
    logic [63:0] m_fifo[$];
    logic [31:0] ret_q[$];

    function automatic int slot_beats(int unsigned a, int left);
        int room = 4 - int'((a >> 3) & 3);
        return (left < room) ? left : room;
    endfunction
    function automatic bit exp_rd_valid();
        return m_rd_left > 0 &&
               (m_fifo.size() + m_rd_out + slot_beats(m_rd_addr, m_rd_left)) <= 16;
    endfunction
    function automatic bit exp_wr_valid();
        return m_wr_left > 0 &&
               (m_fifo.size() - m_wpend) >= slot_beats(m_wr_addr, m_wr_left);
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference update on every edge
    always @(posedge clk) begin : model
        int rb, wb;
        bit rf, wf, pf, pu, sf;
        logic [63:0] pd;
        if (!rst_n) begin
            m_rd_addr = 0; m_wr_addr = 0; m_rd_left = 0; m_wr_left = 0;
            m_rd_out = 0; m_wpend = 0; m_left = 0; m_done = 0;
            m_fifo.delete(); ret_q.delete();
        end else begin
            rb = slot_beats(m_rd_addr, m_rd_left);
            wb = slot_beats(m_wr_addr, m_wr_left);
            rf = exp_rd_valid() && rd_cmd_ready;
            wf = exp_wr_valid() && wr_cmd_ready;
            pf = (m_wpend > 0) && wr_data_ready;
            pu = rd_data_valid;
            pd = rd_data;
            sf = start && m_left == 0 && byte_cnt != 0 && byte_cnt[2:0] == 3'b000;
            m_done = 0;
            if (pf) begin
                void'(m_fifo.pop_front());
                m_wpend--; m_left--;
                if (m_left == 0) m_done = 1;
            end
            if (pu) begin
                void'(ret_q.pop_front());
                m_fifo.push_back(pd);
                m_rd_out--;
            end
            if (rf) begin
                for (int i = 0; i < rb; i++) ret_q.push_back(m_rd_addr + 32'(8 * i));
                m_rd_out += rb; m_rd_addr += 8 * rb; m_rd_left -= rb;
            end
            if (wf) begin
                m_wpend += wb; m_wr_addr += 8 * wb; m_wr_left -= wb;
            end
            if (sf) begin
                m_rd_addr = src_addr; m_wr_addr = dst_addr;
                m_rd_left = byte_cnt / 8; m_wr_left = byte_cnt / 8; m_left = byte_cnt / 8;
            end
        end
    end

    // compare every cycle, then drive the responders
    always @(negedge clk) begin : cmp_drive
        logic [31:0] ra;
        if (rst_n) begin
            check("R3", "rd_cmd_valid", 64'(rd_cmd_valid), 64'(exp_rd_valid()));
            if (exp_rd_valid()) begin
                check("R2", "rd_cmd_addr", 64'(rd_cmd_addr), 64'(m_rd_addr));
                check("R2", "rd_cmd_beats", 64'(rd_cmd_beats), 64'(slot_beats(m_rd_addr, m_rd_left)));
            end
            check("R5", "wr_cmd_valid", 64'(wr_cmd_valid), 64'(exp_wr_valid()));
            if (exp_wr_valid()) begin
                check("R4", "wr_cmd_addr", 64'(wr_cmd_addr), 64'(m_wr_addr));
                check("R4", "wr_cmd_beats", 64'(wr_cmd_beats), 64'(slot_beats(m_wr_addr, m_wr_left)));
            end
            check("R6", "wr_data_valid", 64'(wr_data_valid), 64'(m_wpend > 0));
            if (m_wpend > 0) check("R6", "wr_data", wr_data, m_fifo[0]);
            check("R7", "done", 64'(done), 64'(m_done));
        end
        rd_cmd_ready  = ($urandom_range(0, 99) < rd_pct);
        wr_cmd_ready  = ($urandom_range(0, 99) < wc_pct);
        wr_data_ready = ($urandom_range(0, 99) < wd_pct);
        if (rst_n && ret_q.size() > 0 && $urandom_range(0, 99) < ret_pct) begin
            ra = ret_q[0];
            rd_data_valid = 1'b1;
            rd_data = {ra, ~ra};
        end else begin
            rd_data_valid = 1'b0;
        end
    end

    task automatic kick(int unsigned s, int unsigned d, int n);
        @(negedge clk);
        start = 1'b1; src_addr = s; dst_addr = d; byte_cnt = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic xfer(int unsigned s, int unsigned d, int n);
        kick(s, d, n);
        while (m_left != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        summary();
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "rd_cmd_valid", 64'(rd_cmd_valid), 64'd0);
        check("R1", "wr_cmd_valid", 64'(wr_cmd_valid), 64'd0);
        check("R1", "wr_data_valid", 64'(wr_data_valid), 64'd0);
        check("R1", "done", 64'(done), 64'd0);
        // R2 R4: aligned and misaligned splitting
        xfer(32'h1000, 32'h2000, 64);
        xfer(32'h1008, 32'h3018, 72);
        xfer(32'h0018, 32'h0040, 8);
        xfer(32'h0010, 32'h0090, 16);
        xfer(32'h4000, 32'h5008, 32);
        // R3: slow writer fills the buffer
        wd_pct = 15;
        xfer(32'h6008, 32'h7010, 256);
        wd_pct = 100;
        // R5: slow returns starve the writer
        ret_pct = 15;
        xfer(32'h8000, 32'h9018, 200);
        ret_pct = 100;
        // R8: start while busy, zero and unaligned counts
        kick(32'hA000, 32'hB000, 128);
        repeat (4) @(negedge clk);
        kick(32'hC000, 32'hD000, 64);
        while (m_left != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        kick(32'hE000, 32'hF000, 0);
        kick(32'hE000, 32'hF000, 12);
        repeat (10) @(negedge clk);
        check("R8", "rd_cmd_valid idle", 64'(rd_cmd_valid), 64'd0);
        check("R8", "wr_cmd_valid idle", 64'(wr_cmd_valid), 64'd0);
        // random back-pressure mix
        for (int k = 0; k < 12; k++) begin
            rd_pct = 30 + k * 5; ret_pct = 40 + k * 4; wc_pct = 25 + k * 6; wd_pct = 35 + k * 5;
            xfer(32'h10000 + 32'(k * 8 * 37), 32'h20000 + 32'(k * 8 * 11), 8 * (1 + k * 7));
        end
        summary();
    end
endmodule